// File: doc/BRIEF.md
# Register-Mapped Serial Port with Transmit and Receive Queues

This block is a serial port peripheral reached through six 32-bit word registers. Software pushes bytes into a 16-entry transmit queue by writing the transmit-data register. It pops received bytes from a 16-entry receive queue by reading the receive-data register. A transmit engine serialises queued bytes onto `txd`. A receive engine turns frames on `rxd` back into bytes. A frame is one start bit, eight data bits sent LSB first, an optional even parity bit and one stop bit.

The bit timing comes from the block clock. It passes through a prescaler that divides by 1, 2 or 3, then through a divisor counter that divides by (N+1). The control register holds the enables and three level controls: a transmit-path reset, a receive-path reset and an error clear. Each level control acts for as long as software holds it at 1. The status register reports three sticky error flags, the queue levels and the transmitter activity.

Top module: `uart_fifo_periph`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0x0050_0000, which means receive queue empty (bit 20) and transmit queue empty (bit 22). Control (0x08) and misc (0x10) read 0. The bit-rate register (0x14) reads 0x0180_0000 plus the default divisor.
- R2: The misc register reads back all 32 written bits. Control reads back only its implemented bits, with mask 0x01C0_3000: bit 12 transmit enable, bit 13 receive enable, bit 22 transmit reset, bit 23 receive reset, bit 24 error clear.
- R3: A write to offset 0x00 queues bits 7:0. The queue holds 16 bytes. Status bit 21 is set when the queue is full, and bit 22 is set when it is empty.
- R4: A write to 0x00 while the transmit queue is full is dropped and sets status bit 18. Bit 18 stays set until it is cleared.
- R5: While control bit 24 is held at 1, status bits 16, 17 and 18 are all cleared.
- R6: With control bit 12 set, each queued byte is sent in this order: start 0, data LSB first, even parity only when misc bit 0 is 1, stop 1. Status bit 25 is 1 while a frame is being shifted out. The line is 1 when the transmitter is idle.
- R7: One bit lasts P*(N+1) clock cycles, where N is bit-rate bits 22:0. P is 1 when bit 26 is set, otherwise 2 when bit 27 is set, otherwise 3.
- R8: The receiver accepts a frame only when control bit 13 is set. A read of 0x04 pops one byte and returns it in bits 7:0. A read of 0x04 on an empty queue returns 0 and changes nothing. Status bit 20 is set when the receive queue is empty.
- R9: A frame whose stop bit is 0 sets status bit 17, and its byte is still queued.
- R10: With misc bit 0 set, a received parity bit that differs from the XOR of the data sets status bit 16. With misc bit 0 clear, bit 16 never sets.
- R11: Holding control bit 22 at 1 empties the transmit queue and idles the line. Holding bit 23 at 1 empties the receive queue. Neither one alters any register value.
- R12: The bit-rate register reads back the written value masked with 0x0DFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the bit-rate source |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; pops the receive queue at offset 0x04 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The assertions check on every cycle the rules that follow directly from one cycle to the next:
- the full and empty flags never hold together;
- a write into a full queue raises the overflow flag on the next edge;
- the clear, the transmit reset and the receive reset take effect one cycle after they are held;
- the line stays high whenever the transmitter is idle;
- the parity flag never rises while parity is off.

Only the bench scenarios can show the rest:
- that frames are ordered and timed correctly under each prescaler;
- that bytes survive the loopback path unchanged;
- that the byte of a bad frame is still queued;
- that a disabled receiver ignores a whole frame.

// File: rtl/uart_fifo_pkg.sv
// Package: register offsets, bit positions and line-state type shared by the
// serial port block. Assumes byte addressing with word-aligned registers.
package uart_fifo_pkg;
    localparam int DIV_W = 23;

    localparam logic [4:0] OFS_TXDATA = 5'h00;
    localparam logic [4:0] OFS_RXDATA = 5'h04;
    localparam logic [4:0] OFS_CTRL   = 5'h08;
    localparam logic [4:0] OFS_STAT   = 5'h0C;
    localparam logic [4:0] OFS_MISC   = 5'h10;
    localparam logic [4:0] OFS_BAUD   = 5'h14;

    localparam int ST_PAR     = 16;
    localparam int ST_FRM     = 17;
    localparam int ST_WERR    = 18;
    localparam int ST_RXEMPTY = 20;
    localparam int ST_TXFULL  = 21;
    localparam int ST_TXEMPTY = 22;
    localparam int ST_BUSY    = 25;

    localparam int CT_TXEN  = 12;
    localparam int CT_RXEN  = 13;
    localparam int CT_TXRST = 22;
    localparam int CT_RXRST = 23;
    localparam int CT_CLR   = 24;

    localparam int BD_UNDIV = 26;
    localparam int BD_DIV2  = 27;

    localparam logic [31:0] CTRL_MASK = 32'h01C0_3000;
    localparam logic [31:0] BAUD_MASK = 32'h0DFF_FFFF;

    typedef enum logic [2:0] {
        L_IDLE,
        L_START,
        L_DATA,
        L_PAR,
        L_STOP
    } line_state_e;
endpackage

// File: rtl/uart_sfifo.sv
// Module: synchronous queue with flush. A push while full and a pop while
// empty are ignored. Assumes a single clock and that flush wins over push/pop.
module uart_sfifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Store an accepted entry.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_baud_gen.sv
// Module: bit-rate strobes. A prescaler (divide by 1, 2 or 3) feeds a divisor
// counter (divide by N+1). pre_stb marks each prescaled cycle; bit_tick marks
// each bit boundary. Assumes the divisor may change at any time.
module uart_baud_gen
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_undiv,
    input  logic             sel_div2,
    input  logic [DIV_W-1:0] div_n,
    output logic             pre_stb,
    output logic             bit_tick
);
    logic [1:0]       pre_cnt;
    logic [1:0]       pre_lim;
    logic [DIV_W-1:0] div_cnt;
    logic             div_wrap;

    // Pick the prescaler terminal count.
    always_comb begin
        if (sel_undiv)     pre_lim = 2'd0;
        else if (sel_div2) pre_lim = 2'd1;
        else               pre_lim = 2'd2;
    end

    assign pre_stb  = (pre_cnt >= pre_lim);
    assign div_wrap = (div_cnt >= div_n);
    assign bit_tick = pre_stb && div_wrap;

    // Run the prescaler and divisor counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_stb ? 2'd0 : pre_cnt + 2'd1;
            if (pre_stb) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_engine.sv
// Module: frame serialiser. Loads a byte on a bit tick when idle or in the
// stop bit, then shifts start, data LSB first, optional even parity, stop.
// Assumes bit_tick is one cycle wide; flush forces idle with the line high.
module uart_tx_engine
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       enable,
    input  logic       par_en,
    input  logic       bit_tick,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       txd,
    output logic       busy
);
    line_state_e state;
    logic [7:0]  shreg;
    logic [2:0]  bitn;
    logic        par_q;
    logic        txd_q;

    assign q_pop = bit_tick && enable && !q_empty && !flush &&
                   (state == L_IDLE || state == L_STOP);
    assign txd   = txd_q;
    assign busy  = (state != L_IDLE);

    // Step the frame one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state <= L_IDLE;
            shreg <= '0;
            bitn  <= '0;
            par_q <= 1'b0;
            txd_q <= 1'b1;
        end else if (bit_tick) begin
            case (state)
                L_IDLE, L_STOP: begin
                    if (q_pop) begin
                        shreg <= q_data;
                        par_q <= ^q_data;
                        txd_q <= 1'b0;
                        state <= L_START;
                    end else begin
                        txd_q <= 1'b1;
                        state <= L_IDLE;
                    end
                end
                L_START: begin
                    txd_q <= shreg[0];
                    shreg <= shreg >> 1;
                    bitn  <= '0;
                    state <= L_DATA;
                end
                L_DATA: begin
                    if (bitn == 3'd7) begin
                        txd_q <= par_en ? par_q : 1'b1;
                        state <= par_en ? L_PAR : L_STOP;
                    end else begin
                        txd_q <= shreg[0];
                        shreg <= shreg >> 1;
                        bitn  <= bitn + 3'd1;
                    end
                end
                L_PAR: begin
                    txd_q <= 1'b1;
                    state <= L_STOP;
                end
                default: state <= L_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_engine.sv
// Module: frame deserialiser. Synchronises rxd. Starts on a falling edge,
// confirms the start bit at mid-bit, then samples once per N+1 prescaled
// strobes. Emits a one-cycle push with the byte and its error bits.
// Assumes pre_stb and div_n come from the bit-rate generator.
module uart_rx_engine
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enable,
    input  logic             par_en,
    input  logic             pre_stb,
    input  logic [DIV_W-1:0] div_n,
    input  logic             rxd,
    output logic             push,
    output logic [7:0]       data,
    output logic             frm_err,
    output logic             par_err
);
    line_state_e      state;
    logic             s1, s2, prev;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic             par_bit;
    logic             at_bit;

    assign at_bit = pre_stb && (cnt >= div_n);

    // Bring rxd into the clock domain and keep the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            prev <= s2;
        end
    end

    // Walk through the frame and report the result at the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state   <= L_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            push    <= 1'b0;
            data    <= '0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
        end else begin
            push <= 1'b0;
            case (state)
                L_IDLE: begin
                    if (enable && prev && !s2) begin
                        cnt   <= '0;
                        state <= L_START;
                    end
                end
                L_START: begin
                    if (pre_stb) begin
                        if (cnt >= (div_n >> 1)) begin
                            cnt   <= '0;
                            bitn  <= '0;
                            state <= s2 ? L_IDLE : L_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                L_DATA: begin
                    if (at_bit) begin
                        cnt   <= '0;
                        shreg <= {s2, shreg[7:1]};
                        bitn  <= bitn + 3'd1;
                        if (bitn == 3'd7) state <= par_en ? L_PAR : L_STOP;
                    end else if (pre_stb) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                L_PAR: begin
                    if (at_bit) begin
                        cnt     <= '0;
                        par_bit <= s2;
                        state   <= L_STOP;
                    end else if (pre_stb) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                L_STOP: begin
                    if (at_bit) begin
                        cnt     <= '0;
                        push    <= 1'b1;
                        data    <= shreg;
                        frm_err <= !s2;
                        par_err <= par_en && (par_bit != ^shreg);
                        state   <= L_IDLE;
                    end else if (pre_stb) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= L_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_fifo_periph.sv
// Module: top of the serial port. Decodes six word registers, owns the control,
// misc and bit-rate registers and the sticky error flags, and connects the
// queues, the engines and the bit-rate generator. Assumes single-cycle bus
// strobes and read data that is valid combinationally in the strobe cycle.
module uart_fifo_periph
    import uart_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int DEFAULT_DIV = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        txd,
    input  logic        rxd
);
    localparam logic [31:0] BAUD_RESET = 32'h0180_0000 | (32'(DEFAULT_DIV) & 32'h007F_FFFF);

    logic [31:0] ctrl_q, misc_q, baud_q;
    logic        err_par, err_frm, err_werr;
    logic        tx_full, tx_empty, rx_empty, rx_full;
    logic        tx_pop, tx_busy;
    logic [7:0]  tx_qdata, rx_qdata;
    logic        rx_push, rx_ferr, rx_perr;
    logic [7:0]  rx_byte;
    logic        pre_stb, bit_tick;
    logic        wr_txdata, rd_rxdata;
    logic        tx_rst, rx_rst, clr_err;

    assign tx_rst    = ctrl_q[CT_TXRST];
    assign rx_rst    = ctrl_q[CT_RXRST];
    assign clr_err   = ctrl_q[CT_CLR];
    assign wr_txdata = bus_wr && (bus_addr == OFS_TXDATA);
    assign rd_rxdata = bus_rd && (bus_addr == OFS_RXDATA);

    // Hold the software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            misc_q <= '0;
            baud_q <= BAUD_RESET;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL: ctrl_q <= bus_wdata & CTRL_MASK;
                OFS_MISC: misc_q <= bus_wdata;
                OFS_BAUD: baud_q <= bus_wdata & BAUD_MASK;
                default:  ;
            endcase
        end
    end

    // Collect the sticky error flags; a held clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_err) begin
            err_par  <= 1'b0;
            err_frm  <= 1'b0;
            err_werr <= 1'b0;
        end else begin
            if (rx_push && rx_perr) err_par <= 1'b1;
            if (rx_push && rx_ferr) err_frm <= 1'b1;
            if (wr_txdata && tx_full && !tx_rst) err_werr <= 1'b1;
        end
    end

    // Drive read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RXDATA: bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_qdata};
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_STAT: begin
                bus_rdata[ST_PAR]     = err_par;
                bus_rdata[ST_FRM]     = err_frm;
                bus_rdata[ST_WERR]    = err_werr;
                bus_rdata[ST_RXEMPTY] = rx_empty;
                bus_rdata[ST_TXFULL]  = tx_full;
                bus_rdata[ST_TXEMPTY] = tx_empty;
                bus_rdata[ST_BUSY]    = tx_busy;
            end
            OFS_MISC:   bus_rdata = misc_q;
            OFS_BAUD:   bus_rdata = baud_q;
            default:    bus_rdata = '0;
        endcase
    end

    uart_baud_gen baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_undiv (baud_q[BD_UNDIV]),
        .sel_div2  (baud_q[BD_DIV2]),
        .div_n     (baud_q[DIV_W-1:0]),
        .pre_stb   (pre_stb),
        .bit_tick  (bit_tick)
    );

    uart_sfifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) txq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_rst),
        .push  (wr_txdata),
        .wdata (bus_wdata[7:0]),
        .pop   (tx_pop),
        .rdata (tx_qdata),
        .empty (tx_empty),
        .full  (tx_full)
    );

    uart_tx_engine tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_rst),
        .enable   (ctrl_q[CT_TXEN]),
        .par_en   (misc_q[0]),
        .bit_tick (bit_tick),
        .q_empty  (tx_empty),
        .q_data   (tx_qdata),
        .q_pop    (tx_pop),
        .txd      (txd),
        .busy     (tx_busy)
    );

    uart_rx_engine rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_rst),
        .enable  (ctrl_q[CT_RXEN]),
        .par_en  (misc_q[0]),
        .pre_stb (pre_stb),
        .div_n   (baud_q[DIV_W-1:0]),
        .rxd     (rxd),
        .push    (rx_push),
        .data    (rx_byte),
        .frm_err (rx_ferr),
        .par_err (rx_perr)
    );

    uart_sfifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rxq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_rst),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rd_rxdata),
        .rdata (rx_qdata),
        .empty (rx_empty),
        .full  (rx_full)
    );
endmodule

// File: rtl/uart_fifo_periph_chk.sv
// Module: cycle-level checks on the serial port, attached to every instance
// of the top through bind. Observes ports and internal flags only.
module uart_fifo_periph_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [4:0] bus_addr,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       rx_empty,
    input logic       tx_busy,
    input logic       txd,
    input logic       tx_rst,
    input logic       rx_rst,
    input logic       clr_err,
    input logic       par_en,
    input logic       err_par,
    input logic       err_frm,
    input logic       err_werr
);
    a_r3_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'h00 && tx_full && !tx_rst && !clr_err) |=> err_werr);

    a_r5_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (!err_par && !err_frm && !err_werr));

    a_r6_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    a_r10_no_parity_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_par) |-> $past(par_en, 2));

    a_r11_tx_reset: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst |=> (tx_empty && txd && !tx_busy));

    a_r11_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> rx_empty);
endmodule

bind uart_fifo_periph uart_fifo_periph_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .tx_full  (tx_full),
    .tx_empty (tx_empty),
    .rx_empty (rx_empty),
    .tx_busy  (tx_busy),
    .txd      (txd),
    .tx_rst   (tx_rst),
    .rx_rst   (rx_rst),
    .clr_err  (clr_err),
    .par_en   (misc_q[0]),
    .err_par  (err_par),
    .err_frm  (err_frm),
    .err_werr (err_werr)
);

// File: tb/uart_fifo_periph_tb.sv
// Bench: directed corner cases plus seeded random bytes through a loopback.
module uart_fifo_periph_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd;
    logic        drv_rxd = 1'b1;
    logic        loop = 1'b0;
    logic        rxd;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    assign rxd = loop ? txd : drv_rxd;

    always #5 clk = ~clk;

    uart_fifo_periph dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd)
    );

    function automatic int bit_period(input logic [31:0] baud);
        int pre;
        pre = baud[26] ? 1 : (baud[27] ? 2 : 3);
        return pre * (int'(baud[22:0]) + 1);
    endfunction

    function automatic int low_bits(input logic [7:0] b, input bit par);
        int n;
        n = 1;
        for (int i = 0; i < 8; i++) if (!b[i]) n++;
        if (par && (^b)) n = n;
        else if (par) n++;
        return n;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_tx_done();
        logic [31:0] st;
        int guard;
        guard = 0;
        do begin
            bread(5'h0C, st);
            guard++;
        end while (!(st[22] && !st[25]) && guard < 20000);
        repeat (60) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit par, input bit bad_par,
                              input bit bad_stop, input int p);
        logic [10:0] bits;
        int n;
        bits = '1;
        bits[0] = 1'b0;
        bits[8:1] = b;
        n = 10;
        if (par) begin
            bits[9] = (^b) ^ bad_par;
            n = 11;
        end
        bits[n-1] = !bad_stop;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drv_rxd = bits[i];
            repeat (p - 1) @(negedge clk);
        end
        @(negedge clk);
        drv_rxd = 1'b1;
        repeat (4 * p) @(negedge clk);
    endtask

    task automatic count_low(input int window, output int lows);
        int guard;
        guard = 0;
        lows = 0;
        @(negedge clk);
        while (txd && guard < 10000) begin
            @(negedge clk);
            guard++;
        end
        for (int i = 0; i < window; i++) begin
            if (!txd) lows++;
            @(negedge clk);
        end
    endtask

    task automatic loop_batch(input int n, input string tag);
        logic [7:0]  sent [16];
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            sent[i] = 8'($urandom);
            bwrite(5'h00, {24'h0, sent[i]});
        end
        wait_tx_done();
        for (int i = 0; i < n; i++) begin
            bread(5'h04, d);
            check(tag, d, {24'h0, sent[i]});
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  first [16];
        int lows, p;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bread(5'h0C, d); check("R1 status", d, 32'h0050_0000);
        bread(5'h08, d); check("R1 ctrl", d, 32'h0);
        bread(5'h10, d); check("R1 misc", d, 32'h0);
        bread(5'h14, d); check("R1 baud", d, 32'h0180_0007);

        // R2 / R12 readback
        bwrite(5'h10, 32'hA5C3_0F1E); bread(5'h10, d); check("R2 misc", d, 32'hA5C3_0F1E);
        bwrite(5'h10, 32'h0);
        bwrite(5'h08, 32'hFFFF_FFFF); bread(5'h08, d); check("R2 ctrl mask", d, 32'h01C0_3000);
        bwrite(5'h08, 32'h0);
        bwrite(5'h14, 32'hFFFF_FFFF); bread(5'h14, d); check("R12 baud mask", d, 32'h0DFF_FFFF);
        bwrite(5'h14, 32'h0580_0007);
        p = bit_period(32'h0580_0007);

        // R3 / R4 fill and overflow with transmitter disabled
        for (int i = 0; i < 16; i++) begin
            first[i] = 8'($urandom);
            bwrite(5'h00, {24'h0, first[i]});
        end
        bread(5'h0C, d); check("R3 full/empty bits", {30'h0, d[21], d[22]}, 32'h2);
        check("R4 no error yet", {31'h0, d[18]}, 32'h0);
        bwrite(5'h00, 32'h0000_00EE);
        bread(5'h0C, d); check("R4 overflow flag", {31'h0, d[18]}, 32'h1);
        bwrite(5'h00, 32'h0); // another dropped write
        // R5 clear held then released
        bwrite(5'h08, 32'h0100_0000);
        bread(5'h0C, d); check("R5 cleared", {29'h0, d[18:16]}, 32'h0);
        bwrite(5'h08, 32'h0);

        // R6 busy and R8 loopback of the 16 queued bytes
        loop = 1'b1;
        bwrite(5'h08, 32'h0000_3000);
        repeat (p + 2) @(negedge clk);
        bread(5'h0C, d); check("R6 busy while shifting", {31'h0, d[25]}, 32'h1);
        wait_tx_done();
        for (int i = 0; i < 16; i++) begin
            bread(5'h04, d);
            check("R3 R8 queued byte", d, {24'h0, first[i]});
        end
        bread(5'h0C, d); check("R4 dropped writes absent", {31'h0, d[20]}, 32'h1);
        bread(5'h04, d); check("R8 empty pop reads 0", d, 32'h0);
        bread(5'h0C, d); check("R8 still empty", {31'h0, d[20]}, 32'h1);

        // Random loopback, parity off then on
        loop_batch(10, "R6 R8 loopback no parity");
        bread(5'h0C, d); check("R10 no parity error when off", {30'h0, d[17:16]}, 32'h0);
        bwrite(5'h10, 32'h1);
        loop_batch(12, "R6 R10 loopback even parity");
        bread(5'h0C, d); check("R10 good parity no flag", {30'h0, d[17:16]}, 32'h0);

        // R10 bad parity from the line
        loop = 1'b0;
        send_frame(8'h3C, 1'b1, 1'b1, 1'b0, p);
        bread(5'h0C, d); check("R10 parity flag", {31'h0, d[16]}, 32'h1);
        bread(5'h04, d); check("R10 byte kept", d, 32'h3C);
        bwrite(5'h08, 32'h0100_3000); bwrite(5'h08, 32'h0000_3000);

        // R9 framing error, parity off
        bwrite(5'h10, 32'h0);
        send_frame(8'h81, 1'b0, 1'b0, 1'b1, p);
        bread(5'h0C, d); check("R9 framing flag", {31'h0, d[17]}, 32'h1);
        bread(5'h04, d); check("R9 byte kept", d, 32'h81);
        bwrite(5'h08, 32'h0100_3000);
        bread(5'h0C, d); check("R5 flags cleared", {29'h0, d[18:16]}, 32'h0);
        bwrite(5'h08, 32'h0000_3000);
        bread(5'h0C, d); check("R10 stays clear after release", {31'h0, d[16]}, 32'h0);

        // R8 receiver disabled ignores a frame
        bwrite(5'h08, 32'h0000_1000);
        send_frame(8'h55, 1'b0, 1'b0, 1'b0, p);
        bread(5'h0C, d); check("R8 disabled receiver", {31'h0, d[20]}, 32'h1);

        // R11 receive reset
        bwrite(5'h08, 32'h0000_3000);
        send_frame(8'h12, 1'b0, 1'b0, 1'b0, p);
        send_frame(8'h34, 1'b0, 1'b0, 1'b0, p);
        bread(5'h0C, d); check("R11 rx holds data", {31'h0, d[20]}, 32'h0);
        bwrite(5'h10, 32'h0000_00F0);
        bwrite(5'h08, 32'h0080_3000); bwrite(5'h08, 32'h0000_3000);
        bread(5'h0C, d); check("R11 rx flushed", {31'h0, d[20]}, 32'h1);
        bread(5'h08, d); check("R11 ctrl unchanged", d, 32'h0000_3000);
        bread(5'h10, d); check("R11 misc unchanged", d, 32'h0000_00F0);
        bwrite(5'h10, 32'h0);

        // R11 transmit reset
        bwrite(5'h08, 32'h0);
        bwrite(5'h00, 32'h11); bwrite(5'h00, 32'h22); bwrite(5'h00, 32'h33);
        bread(5'h0C, d); check("R11 tx queued", {31'h0, d[22]}, 32'h0);
        bwrite(5'h08, 32'h0040_0000); bwrite(5'h08, 32'h0);
        bread(5'h0C, d); check("R11 tx flushed", {31'h0, d[22]}, 32'h1);
        bread(5'h14, d); check("R11 baud unchanged", d, 32'h0580_0007);

        // R6 frame shape: LSB first and parity bit, measured by low time
        bwrite(5'h08, 32'h0000_1000);
        bwrite(5'h00, 32'hFE);
        count_low(11 * p, lows);
        check("R6 LSB first", lows, low_bits(8'hFE, 1'b0) * p);
        wait_tx_done();
        bwrite(5'h10, 32'h1);
        bwrite(5'h00, 32'h7E);
        count_low(12 * p, lows);
        check("R6 even parity bit", lows, low_bits(8'h7E, 1'b1) * p);
        wait_tx_done();
        bwrite(5'h10, 32'h0);

        // R7 prescaler modes
        begin
            logic [31:0] modes [3];
            modes[0] = 32'h0580_0007;
            modes[1] = 32'h0980_0007;
            modes[2] = 32'h0180_0004;
            for (int m = 0; m < 3; m++) begin
                bwrite(5'h14, modes[m]);
                bwrite(5'h00, 32'hFF);
                count_low(11 * bit_period(modes[m]), lows);
                check("R7 bit period", lows, bit_period(modes[m]));
                wait_tx_done();
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule